// File: doc/BRIEF.md
# Burner Purge and Ignition Interlock

This block is a safety interlock for the burner of an industrial heater. It works as a fixed-rate scan loop. At the start of each scan it freezes its five control inputs into a snapshot. It then evaluates a purge latch, a purge-completion on-delay and a bounded ignition-permission window against that frozen snapshot. At the end of the scan it publishes all results together.

A purge starts on a plant-wide shutdown demand or on a manual start. It is blocked or aborted when the purge-allow input is low or the purge-abort input is high. A purge completes after the latch has been held for `T1_SCANS` consecutive scans. Ignition permission is then granted while the fuel header is ready. It lasts at most `T2_SCANS` scans, and the purge-abort input withdraws it at once. Granting ignition ends the purge.

The scan length is `SCAN_CLKS` clock cycles. A one-cycle `scan_done_o` strobe marks each publication, so surrounding logic or a reference model can follow the block scan by scan.

Top module: `purge_interlock`

## Requirements
- R1: Inputs are captured on the first clock edge of each scan. Any change after that edge has no effect on that scan's published results.
- R2: `scan_done_o` is high for exactly one clock cycle every `SCAN_CLKS` cycles. All three result outputs change only in a cycle where `scan_done_o` is high.
- R3: The purge latch (`purge_active_o`) becomes 1 in a scan whose snapshot has `shutdown_all_i` or `manual_start_i` high. It then holds 1 until a clear condition occurs.
- R4: The latch clear has priority over set. A snapshot with `purge_allow_i` low or `purge_abort_i` high yields `purge_active_o` = 0, even when a set input is high.
- R5: `purge_done_o` is 1 in the `T1_SCANS`-th and later consecutive scans in which the latch is 1. It is 0 in any scan where the latch is 0.
- R6: `ignite_ok_o` can rise only in a scan where `purge_done_o` is 1 and the snapshot has `header_ok_i` high.
- R7: Once granted, `ignite_ok_o` stays 1 while `header_ok_i` stays high and abort stays low, for at most `T2_SCANS` consecutive scans. A snapshot with `header_ok_i` low ends it.
- R8: A snapshot with `purge_abort_i` high gives `ignite_ok_o` = 0 in that same scan.
- R9: The scan after one in which `ignite_ok_o` was 1 publishes `purge_active_o` = 0.
- R10: Asserting `rst_ni` low drives all outputs to 0 and clears the latch, both timers and the snapshot. The next scan starts from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shutdown_all_i | input | 1 | Plant-wide shutdown demand (purge set) |
| manual_start_i | input | 1 | Operator purge start (purge set) |
| purge_allow_i | input | 1 | Purge allowed; low clears or blocks the latch |
| purge_abort_i | input | 1 | Purge abort; clears latch and ignition |
| header_ok_i | input | 1 | Fuel header ready |
| purge_active_o | output | 1 | Purge in progress (latch state) |
| purge_done_o | output | 1 | Purge completed (T1 on-delay output) |
| ignite_ok_o | output | 1 | Ignition permitted |
| scan_done_o | output | 1 | One-cycle strobe when outputs update |

## Verification
The bench runs scans in which set and clear arrive together. A set-dominant latch would then report a purge still running. It also drops `header_ok_i` just as a purge completes, and keeps `header_ok_i` up long enough to reach the `T2_SCANS` limit. An off-by-one timer shows up there as a grant that is one scan early, one scan late or one scan too long. Some scans invert every input right after the capture edge. A design that samples late or combinationally would then publish the inverted result. A long pseudo-random run compares every published scan against an arithmetic model, including abort during ignition and loss of permission mid-purge.

// File: rtl/purge_pkg.sv
package purge_pkg;
  typedef struct packed {
    logic shutdown_all;
    logic manual_start;
    logic allow;
    logic abort;
    logic header;
  } snap_t;
endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int SCAN_CLKS = 4,
  localparam int CW = (SCAN_CLKS > 1) ? $clog2(SCAN_CLKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic capture_o,
  output logic publish_o
);
  localparam logic [CW-1:0] LAST = CW'(SCAN_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign capture_o = (cnt_q == '0);
  assign publish_o = (cnt_q == LAST);

  // R1
  capture_before_publish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    publish_o |=> capture_o);
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int MAX_CNT = 3,
  localparam int W = $clog2(MAX_CNT + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_next_o
);
  localparam logic [W-1:0] MAX_L = W'(MAX_CNT);

  logic [W-1:0] cnt_q;

  // saturating elapsed-scan count, cleared when the enable is low
  always_comb begin
    if (!en_i)               cnt_next_o = '0;
    else if (cnt_q == MAX_L) cnt_next_o = cnt_q;
    else                     cnt_next_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_next_o;
  end

  // R5
  timer_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_L);
  // R5
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/purge_interlock.sv
module purge_interlock #(
  parameter int SCAN_CLKS = 4,
  parameter int T1_SCANS  = 3,
  parameter int T2_SCANS  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shutdown_all_i,
  input  logic manual_start_i,
  input  logic purge_allow_i,
  input  logic purge_abort_i,
  input  logic header_ok_i,
  output logic purge_active_o,
  output logic purge_done_o,
  output logic ignite_ok_o,
  output logic scan_done_o
);
  import purge_pkg::*;

  localparam int W1 = $clog2(T1_SCANS + 1);
  localparam int W2 = $clog2(T2_SCANS + 2);
  localparam logic [W1-1:0] T1_L = W1'(T1_SCANS);
  localparam logic [W2-1:0] T2_L = W2'(T2_SCANS);

  logic  capture, publish;
  snap_t snap_q;
  logic  latch_q, done_q, ign_q, scan_done_q;
  logic  set_c, clr_c, latch_n, done_n, cand_n, ign_n;
  logic [W1-1:0] c1_n;
  logic [W2-1:0] c2_n;

  scan_sequencer #(.SCAN_CLKS(SCAN_CLKS)) u_seq (
    .clk_i, .rst_ni, .capture_o(capture), .publish_o(publish)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= '0;
    else if (capture) snap_q <= '{shutdown_all: shutdown_all_i, manual_start: manual_start_i,
                                  allow: purge_allow_i, abort: purge_abort_i,
                                  header: header_ok_i};
  end

  // reset-dominant purge latch; a granted ignition ends the purge
  assign set_c   = snap_q.shutdown_all | snap_q.manual_start;
  assign clr_c   = !snap_q.allow | snap_q.abort | ign_q;
  assign latch_n = !clr_c & (set_c | latch_q);

  scan_timer #(.MAX_CNT(T1_SCANS)) u_t1 (
    .clk_i, .rst_ni, .step_i(publish), .en_i(latch_n), .cnt_next_o(c1_n)
  );
  assign done_n = latch_n && (c1_n >= T1_L);

  // ignition window: opened by completion, held by itself, bounded by T2
  assign cand_n = (done_n | ign_q) & snap_q.header & !snap_q.abort;

  scan_timer #(.MAX_CNT(T2_SCANS + 1)) u_t2 (
    .clk_i, .rst_ni, .step_i(publish), .en_i(cand_n), .cnt_next_o(c2_n)
  );
  assign ign_n = cand_n && (c2_n <= T2_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q     <= 1'b0;
      done_q      <= 1'b0;
      ign_q       <= 1'b0;
      scan_done_q <= 1'b0;
    end else begin
      scan_done_q <= publish;
      if (publish) begin
        latch_q <= latch_n;
        done_q  <= done_n;
        ign_q   <= ign_n;
      end
    end
  end

  assign purge_active_o = latch_q;
  assign purge_done_o   = done_q;
  assign ignite_ok_o    = ign_q;
  assign scan_done_o    = scan_done_q;

  // independent run-length counter for the ignition bound
  logic [W2-1:0] ign_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ign_run_q <= '0;
    else if (publish) ign_run_q <= ign_n ? ((ign_run_q > T2_L) ? ign_run_q : ign_run_q + 1'b1) : '0;
  end

  // R2
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o);
  // R2
  publish_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_done_o |-> $stable({purge_active_o, purge_done_o, ignite_ok_o}));
  // R4
  allow_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_done_o && !snap_q.allow) |-> !purge_active_o);
  // R5
  done_needs_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge_done_o |-> purge_active_o);
  // R6
  ignite_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ignite_ok_o) |-> (purge_done_o && snap_q.header));
  // R7
  ignite_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ign_run_q <= T2_L);
  // R8
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_done_o && snap_q.abort) |-> (!ignite_ok_o && !purge_active_o));
  // R9
  ignite_ends_purge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (publish && ign_q) |=> !purge_active_o);
endmodule

// File: tb/tb_purge_interlock.sv
module tb_purge_interlock;
  localparam int SCAN_CLKS = 4;
  localparam int T1 = 3;
  localparam int T2 = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sd = 0, ms = 0, pa = 0, ab = 0, hd = 0;
  logic act, done, ign, sdone;

  int n_chk = 0, n_bad = 0;
  int m_c1 = 0, m_c2 = 0;
  logic m_l = 0, m_d = 0, m_g = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  purge_interlock #(.SCAN_CLKS(SCAN_CLKS), .T1_SCANS(T1), .T2_SCANS(T2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .shutdown_all_i(sd), .manual_start_i(ms),
    .purge_allow_i(pa), .purge_abort_i(ab), .header_ok_i(hd),
    .purge_active_o(act), .purge_done_o(done), .ignite_ok_o(ign), .scan_done_o(sdone)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // arithmetic scan model built from the requirements
  task automatic model_scan(input logic s, m, a, b, h);
    logic l_n, c_n;
    l_n = !(!a || b || m_g) && (s || m || m_l);
    m_c1 = l_n ? ((m_c1 < T1) ? m_c1 + 1 : m_c1) : 0;
    m_d = l_n && (m_c1 >= T1);
    c_n = (m_d || m_g) && h && !b;
    m_c2 = c_n ? ((m_c2 <= T2) ? m_c2 + 1 : m_c2) : 0;
    m_g = c_n && (m_c2 <= T2);
    m_l = l_n;
  endtask

  // one scan: drive at capture cycle, optionally invert after capture, wait for publish
  task automatic scan(input logic s, m, a, b, h, input bit glitch, input string tag);
    int waited;
    logic p_act, p_done, p_ign;
    p_act = act; p_done = done; p_ign = ign;
    sd = s; ms = m; pa = a; ab = b; hd = h;
    waited = 0;
    forever begin
      @(negedge clk);
      waited++;
      if (sdone) break;
      if (glitch && waited == 1) begin
        sd = !s; ms = !m; pa = !a; ab = !b; hd = !h;
      end
      if ({act, done, ign} != {p_act, p_done, p_ign}) chk("R2 outputs moved mid-scan", 1, 0);
      if (waited > 4 * SCAN_CLKS) begin
        chk("R2 scan strobe missing", 0, 1);
        break;
      end
    end
    chk("R2 scan period", waited, SCAN_CLKS);
    model_scan(s, m, a, b, h);
    chk({tag, " purge_active"}, act, m_l);
    chk({tag, " purge_done"}, done, m_d);
    chk({tag, " ignite_ok"}, ign, m_g);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    sd = 0; ms = 0; pa = 0; ab = 0; hd = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset active", act, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset ignite", ign, 0);
    chk("R10 reset strobe", sdone, 0);
    m_l = 0; m_d = 0; m_g = 0; m_c1 = 0; m_c2 = 0;
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    chk("watchdog expired", 1, 0);
    summary_and_end();
  end

  initial begin
    int g_run;
    do_reset();

    // R3 idle: no set input, latch stays low
    scan(0, 0, 1, 0, 1, 0, "R3 idle");
    scan(0, 0, 1, 0, 1, 0, "R3 idle");
    // R3 manual start, header low so no ignition yet (R6)
    scan(0, 1, 1, 0, 0, 0, "R3 manual set");
    scan(0, 0, 1, 0, 0, 0, "R5 hold 2");
    scan(0, 0, 1, 0, 0, 0, "R5 completes at T1");
    chk("R5 done at T1", done, 1);
    scan(0, 0, 1, 0, 0, 0, "R6 no header");
    chk("R6 no ignite without header", ign, 0);
    scan(0, 0, 1, 0, 1, 0, "R6 header grants");
    chk("R6 granted", ign, 1);
    scan(0, 0, 1, 0, 1, 0, "R9 purge ends");
    chk("R9 latch cleared after grant", act, 0);
    g_run = 2;
    for (int i = 0; i < T2; i++) begin
      scan(0, 0, 1, 0, 1, 0, "R7 window");
      if (ign) g_run++;
    end
    chk("R7 grant length", g_run, T2);

    // R4 set and clear together
    scan(1, 1, 1, 1, 0, 0, "R4 set with abort");
    chk("R4 abort dominates", act, 0);
    scan(1, 0, 0, 0, 0, 0, "R4 set without allow");
    chk("R4 allow low dominates", act, 0);
    // R5 abort before completion resets the on-delay
    scan(1, 0, 1, 0, 0, 0, "R3 shutdown set");
    scan(0, 0, 1, 0, 0, 0, "R5 partial");
    scan(0, 0, 1, 1, 0, 0, "R5 abort mid");
    scan(0, 1, 1, 0, 0, 0, "R5 restart");
    scan(0, 0, 1, 0, 0, 0, "R5 restart 2");
    chk("R5 not done before T1", done, 0);
    scan(0, 0, 1, 0, 1, 0, "R5 restart 3");
    chk("R5 done after full T1", done, 1);
    // R8 abort withdraws ignition in the same scan
    scan(0, 0, 1, 1, 1, 0, "R8 abort in window");
    chk("R8 ignite withdrawn", ign, 0);
    // R7 header loss ends the window
    scan(0, 1, 1, 0, 1, 0, "R7 set");
    scan(0, 0, 1, 0, 1, 0, "R7 set 2");
    scan(0, 0, 1, 0, 1, 0, "R7 grant");
    scan(0, 0, 1, 0, 0, 0, "R7 header lost");
    chk("R7 header loss ends grant", ign, 0);

    // R1 inputs inverted right after capture
    scan(0, 1, 1, 0, 0, 1, "R1 glitch set");
    scan(0, 0, 1, 0, 0, 1, "R1 glitch hold");
    scan(0, 0, 1, 1, 0, 1, "R1 glitch abort");
    chk("R1 snapshot used", act, 0);

    // R10 reset in the middle of a purge
    scan(0, 1, 1, 0, 0, 0, "R10 pre");
    do_reset();
    scan(0, 0, 1, 0, 0, 0, "R10 clean restart");

    // near-exhaustive pseudo-random scan stream
    for (int i = 0; i < 800; i++) begin
      logic [4:0] r;
      for (int k = 0; k < 5; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr[4:0];
      scan(lfsr[2:0] == 3'd0, lfsr[5:3] == 3'd1, lfsr[8:6] != 3'd0, lfsr[12:9] == 4'd0,
           lfsr[14:13] != 2'd0, r[0] & r[3] & r[4],
           "R3/R4/R5/R6/R7/R8/R9 random");
    end

    summary_and_end();
  end
endmodule